// File: doc/BRIEF.md
# Serial-Bus Configuration Register Slave with Select-Driven Banks

This block is a two-wire serial slave that holds sixteen 8-bit control bytes for a clock-synthesis datapath. The bus lines are oversampled by the system clock. A bus master writes one byte by sending a START, the device address with the direction bit low, a register index and the data byte. To read one byte, the master sends the index the same way, issues a repeated START, sends the device address with the direction bit high and clocks the byte out.

All sixteen bytes are presented in parallel on a flat output vector. Two pairs of bytes hold alternate settings for the third synthesizer path and its output steering, labelled C and D. A live select input chooses which byte of each pair drives the resolved C and D outputs, so the configuration changes with no bus traffic.

Top module: `clkcfg_i2c_regs`

## Requirements
- R1: After reset every byte reads zero, both resolved path outputs are zero and the slave does not pull SDA.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP abandons any partial transfer without changing a register. The slave changes its SDA pull only while SCL is low.
- R3: An address byte whose upper seven bits equal the DEV_ADDR parameter (default 7'h58) is acknowledged by pulling SDA low during the ninth clock. Bit 0 of that byte is the direction: 0 is write, 1 is read.
- R4: An address byte with any other upper seven bits is not acknowledged. The slave then ignores all bus activity and changes no register until the next START.
- R5: A register index byte of 0 to 15 is acknowledged. An index of 16 or more is not acknowledged, and the slave changes no register until the next START.
- R6: In a write transfer, the byte that follows an accepted index is stored at that index and acknowledged. Byte n appears on regs_o bits [8n+7:8n].
- R7: After a repeated START and an address byte with direction 1, the slave shifts out the byte at the last accepted index, most significant bit first. For each bit it pulls SDA low for a 0 and releases SDA for a 1.
- R8: path_c_o shows byte 10 while bank_sel_i is low and byte 11 while it is high. path_d_o shows byte 12 while bank_sel_i is low and byte 13 while it is high. Both outputs follow a change of bank_sel_i or of those bytes one system clock later, with no bus transfer needed.
- R9: After one data byte has been stored, further bytes in the same transfer are not acknowledged and are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired level) |
| bank_sel_i | input | 1 | Selects the alternate C/D control bytes |
| sda_pull_o | output | 1 | 1 = drive SDA low, 0 = release |
| regs_o | output | 128 | All sixteen register bytes, byte n at [8n+7:8n] |
| path_c_o | output | 8 | Bank-resolved control byte for the C path |
| path_d_o | output | 8 | Bank-resolved control byte for the D path |

## Verification
The assertions assume that the master never issues a START or STOP while the slave is pulling SDA. They also assume that every SCL level lasts several system clocks, so that after synchronization an SDA change never reaches the logic in the same cycle as an SCL edge. The stimulus meets both conditions: it holds each SCL phase for six system clocks and changes SDA only while SCL is low, except for deliberate START and STOP edges. It also releases SDA in every slot that belongs to the slave. bank_sel_i is driven on the falling clock edge, so it is synchronous to the block.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_REG,
    ST_ACK_REG,
    ST_WDAT,
    ST_ACK_WDAT,
    ST_RDAT,
    ST_RACK
  } bus_st_e;
endpackage

// File: rtl/clkcfg_sync_edge.sv
module clkcfg_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/clkcfg_bus_fsm.sv
module clkcfg_bus_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h58,
  parameter int unsigned NREGS    = 16,
  localparam int unsigned AW      = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     ptr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_pull_o
);
  bus_st_e           st, st_n;
  logic [3:0]        cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              rw, rw_n;
  logic [AW-1:0]     ptr, ptr_n;
  logic              pull, pull_n;
  logic              wr_en;
  logic              byte_done;

  assign byte_done = scl_fall && (cnt == 4'd8);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    sh_n   = sh;
    rw_n   = rw;
    ptr_n  = ptr;
    pull_n = pull;
    wr_en  = 1'b0;
    if (stop_ev) begin
      st_n   = ST_IDLE;
      pull_n = 1'b0;
    end else if (start_ev) begin
      st_n   = ST_DEV;
      cnt_n  = 4'd0;
      pull_n = 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_REG, ST_WDAT: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_lvl};
            cnt_n = cnt + 4'd1;
          end else if (byte_done) begin
            cnt_n = 4'd0;
            if (st == ST_DEV) begin
              if (sh[7:1] == DEV_ADDR) begin
                rw_n   = sh[0];
                pull_n = 1'b1;
                st_n   = ST_ACK_DEV;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st == ST_REG) begin
              if (int'(sh) < int'(NREGS)) begin
                ptr_n  = sh[AW-1:0];
                pull_n = 1'b1;
                st_n   = ST_ACK_REG;
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              wr_en  = 1'b1;
              pull_n = 1'b1;
              st_n   = ST_ACK_WDAT;
            end
          end
        end
        ST_ACK_DEV: begin
          if (scl_fall) begin
            cnt_n = 4'd0;
            if (rw) begin
              sh_n   = rd_data;
              pull_n = ~rd_data[BYTE_W-1];
              st_n   = ST_RDAT;
            end else begin
              pull_n = 1'b0;
              st_n   = ST_REG;
            end
          end
        end
        ST_ACK_REG: begin
          if (scl_fall) begin
            pull_n = 1'b0;
            cnt_n  = 4'd0;
            st_n   = ST_WDAT;
          end
        end
        ST_ACK_WDAT: begin
          if (scl_fall) begin
            pull_n = 1'b0;
            st_n   = ST_IDLE;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (byte_done) begin
            pull_n = 1'b0;
            st_n   = ST_RACK;
          end else if (scl_fall) begin
            sh_n   = {sh[BYTE_W-2:0], 1'b1};
            pull_n = ~sh[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise) st_n = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= 4'd0;
      sh   <= '0;
      rw   <= 1'b0;
      ptr  <= '0;
      pull <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      sh   <= sh_n;
      rw   <= rw_n;
      ptr  <= ptr_n;
      pull <= pull_n;
    end
  end

  assign ptr_o      = ptr;
  assign wr_en_o    = wr_en;
  assign wr_data_o  = sh;
  assign sda_pull_o = pull;

  // R2: the SDA pull only moves while SCL is low
  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull) |-> !scl_lvl);

  // R2: a START re-arms address reception and releases SDA
  p_start_rearms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !stop_ev) |=> (st == ST_DEV) && !pull);

  // R5: an out-of-range index is refused
  p_bad_index_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REG && byte_done && int'(sh) >= int'(NREGS) && !start_ev && !stop_ev)
      |=> (st == ST_IDLE) && !pull);

  // R6: a stored byte is acknowledged
  p_write_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pull && (st == ST_ACK_WDAT));

  // R4: a foreign address never leads to a pull
  p_foreign_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !start_ev) |=> !pull);
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int unsigned NREGS  = 16,
  parameter int unsigned C_SEL0 = 10,
  parameter int unsigned C_SEL1 = 11,
  parameter int unsigned D_SEL0 = 12,
  parameter int unsigned D_SEL1 = 13,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic                    sel_i,
  output logic [BYTE_W-1:0]       rd_data,
  output logic [NREGS*BYTE_W-1:0] regs_o,
  output logic [BYTE_W-1:0]       path_c_o,
  output logic [BYTE_W-1:0]       path_d_o
);
  logic [BYTE_W-1:0] regs_q [NREGS];
  logic              sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREGS); i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_i;
  end

  generate
    for (genvar g = 0; g < int'(NREGS); g++) begin : g_flat
      assign regs_o[g*BYTE_W +: BYTE_W] = regs_q[g];
    end
  endgenerate

  assign rd_data  = regs_q[addr];
  assign path_c_o = sel_q ? regs_q[C_SEL1] : regs_q[C_SEL0];
  assign path_d_o = sel_q ? regs_q[D_SEL1] : regs_q[D_SEL0];

  // R6: a write strobe lands in the addressed byte
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(addr)] == $past(wr_data));

  // R8: with no write and a steady select, resolved outputs hold
  p_path_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $stable(sel_i)) |=> $stable(path_c_o) && $stable(path_d_o));
endmodule

// File: rtl/clkcfg_i2c_regs.sv
module clkcfg_i2c_regs
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h58,
  parameter int unsigned NREGS       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW         = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic                    bank_sel_i,
  output logic                    sda_pull_o,
  output logic [NREGS*BYTE_W-1:0] regs_o,
  output logic [BYTE_W-1:0]       path_c_o,
  output logic [BYTE_W-1:0]       path_d_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_ev, stop_ev;
  logic              wr_en;
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  clkcfg_sync_edge #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  clkcfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;

  clkcfg_bus_fsm #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .ptr_o(ptr), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .sda_pull_o(sda_pull_o));

  clkcfg_regbank #(.NREGS(NREGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr),
    .wr_data(wr_data), .sel_i(bank_sel_i), .rd_data(rd_data),
    .regs_o(regs_o), .path_c_o(path_c_o), .path_d_o(path_d_o));
endmodule

// File: tb/tb_clkcfg_i2c_regs.sv
`timescale 1ns/1ps
module tb_clkcfg_i2c_regs;
  localparam logic [6:0] DEV = 7'h58;
  localparam int Q = 6;

  logic clk, rst_n, scl_m, sda_m, sel;
  logic sda_pull;
  logic [127:0] regs;
  logic [7:0] path_c, path_d;
  wire  sda_line = sda_m & ~sda_pull;

  int tests = 0, fails = 0;
  bit done = 0, cmp_en = 0;
  logic [7:0] mem [16];
  logic sel_seen;

  clkcfg_i2c_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .bank_sel_i(sel), .sda_pull_o(sda_pull), .regs_o(regs),
    .path_c_o(path_c), .path_d_o(path_d));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference for the resolved outputs, compared on every clock while idle
  always @(posedge clk) sel_seen <= sel;
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk(path_c == (sel_seen ? mem[11] : mem[10]), "R8 path_c", path_c, sel_seen ? mem[11] : mem[10]);
      chk(path_d == (sel_seen ? mem[13] : mem[12]), "R8 path_d", path_d, sel_seen ? mem[13] : mem[12]);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0; wt(2);
    end
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    ack = !sda_line;
    scl_m = 1'b0; wt(2);
  endtask

  task automatic recv(output logic [7:0] b, input bit nack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1'b1; wt(Q); b[i] = sda_line; scl_m = 1'b0;
    end
    wt(2); sda_m = nack; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0; wt(2);
    sda_m = 1'b1;
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++)
      chk(regs[8*i +: 8] == mem[i], req, regs[8*i +: 8], mem[i]);
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    bit a1, a2, a3;
    cmp_en = 0;
    bus_start();
    send({DEV, 1'b0}, a1);
    send(idx, a2);
    send(d, a3);
    bus_stop(); wt(4);
    chk(a1, "R3 address ack", a1, 1);
    chk(a2, "R5 index ack", a2, 1);
    chk(a3, "R6 data ack", a3, 1);
    mem[idx[3:0]] = d;
    chk(regs[8*idx[3:0] +: 8] == d, "R6 stored byte", regs[8*idx[3:0] +: 8], d);
    cmp_en = 1;
  endtask

  task automatic rd_reg(input logic [7:0] idx);
    bit a1, a2, a3;
    logic [7:0] got;
    cmp_en = 0;
    bus_start();
    send({DEV, 1'b0}, a1);
    send(idx, a2);
    bus_start();
    send({DEV, 1'b1}, a3);
    recv(got, 1'b1);
    bus_stop(); wt(4);
    chk(a1 && a2 && a3, "R7 acks in read", {a1, a2, a3}, 3'b111);
    chk(got == mem[idx[3:0]], "R7 read data", got, mem[idx[3:0]]);
    cmp_en = 1;
  endtask

  initial begin
    bit a1, a2, a3;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; sel = 1'b0;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    wt(5); rst_n = 1'b1; wt(4);
    check_all("R1 reset byte");
    chk(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
    chk(path_c == 8'h00 && path_d == 8'h00, "R1 paths zero", {path_c, path_d}, 0);
    cmp_en = 1;

    wr_reg(8'd10, 8'hA5);
    wr_reg(8'd11, 8'h3C);
    wr_reg(8'd12, 8'h0F);
    wr_reg(8'd13, 8'hF0);
    wr_reg(8'd0,  8'h81);
    wr_reg(8'd15, 8'h7E);
    check_all("R6 register file");

    rd_reg(8'd10);
    rd_reg(8'd15);
    rd_reg(8'd0);
    rd_reg(8'd13);

    // R8: swap banks with no bus traffic
    sel = 1'b1; wt(3);
    chk(path_c == 8'h3C, "R8 path_c sel1", path_c, 8'h3C);
    chk(path_d == 8'hF0, "R8 path_d sel1", path_d, 8'hF0);
    sel = 1'b0; wt(3);
    chk(path_c == 8'hA5, "R8 path_c sel0", path_c, 8'hA5);
    sel = 1'b1;
    wr_reg(8'd11, 8'h5A);
    chk(path_c == 8'h5A, "R8 follows write", path_c, 8'h5A);
    sel = 1'b0; wt(2);

    // R4: foreign address, following bytes ignored
    cmp_en = 0;
    bus_start();
    send({7'h21, 1'b0}, a1);
    send(8'd3, a2);
    send(8'hEE, a3);
    bus_stop(); wt(4);
    chk(!a1 && !a2 && !a3, "R4 no ack on foreign address", {a1, a2, a3}, 0);
    check_all("R4 registers unchanged");
    cmp_en = 1;

    // R5: index out of range
    cmp_en = 0;
    bus_start();
    send({DEV, 1'b0}, a1);
    send(8'h13, a2);
    send(8'h99, a3);
    bus_stop(); wt(4);
    chk(a1 && !a2 && !a3, "R5 nack on index 0x13", {a1, a2, a3}, 3'b100);
    check_all("R5 registers unchanged");
    cmp_en = 1;

    // R2: STOP in the middle abandons the transfer
    cmp_en = 0;
    bus_start();
    send({DEV, 1'b0}, a1);
    send(8'd6, a2);
    bus_stop(); wt(4);
    chk(a1 && a2, "R2 acks before stop", {a1, a2}, 2'b11);
    check_all("R2 abort leaves registers");
    cmp_en = 1;
    wr_reg(8'd6, 8'h42);

    // R9: second data byte refused
    cmp_en = 0;
    bus_start();
    send({DEV, 1'b0}, a1);
    send(8'd5, a2);
    send(8'h11, a3);
    chk(a3, "R9 first data ack", a3, 1);
    send(8'h22, a3);
    bus_stop(); wt(4);
    chk(!a3, "R9 second data nack", a3, 0);
    mem[5] = 8'h11;
    check_all("R9 only first byte stored");
    cmp_en = 1;
    rd_reg(8'd5);

    wt(10);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule